// File: doc/BRIEF.md
# Forced-Idle Residency Counter Bank

This block measures how much execution time is lost to forced idling. It has a per-thread view, a per-core view and a package view. Each cycle it takes one forced-idle flag per logical processor and the package's current C-state code. Logical processors are grouped into cores in contiguous runs of `LP_PER_CORE`: core `c` owns threads `c*LP_PER_CORE` up to `c*LP_PER_CORE+LP_PER_CORE-1`.

The block keeps one stall counter per thread and one residency counter per core. It also keeps two package counters. The shallow package counter counts cycles in C-state code 2 that have some thread forced idle. The deep package counter counts cycles in a C-state code that software picks through a small configuration register. Software reads any counter through a request/response port. The port selects a counter class by address and, for thread and core counters, an instance by index.

The read port is a two-state machine. In `RD_IDLE`, `rd_valid` is low. The transition `IDLE_TO_RESP` is taken on `rd_en`. `RESP_TO_RESP` is taken when the next read arrives at once. `RESP_TO_IDLE` is taken when no read follows. In `RD_RESP`, `rd_valid` is high and `rd_data` holds the captured value.

Top module: `idle_residency_bank`

## Requirements
- R1: The thread counter `i` adds one on each cycle that `lp_idle[i]` is 1. A read at address 0xDB2 with `rd_idx = i` returns it.
- R2: The core counter `c` adds one on each cycle that any thread of core `c` is idle. A read at address 0x653 with `rd_idx = c` returns it.
- R3: The shallow package counter adds one on each cycle where `cstate == 2` and at least one `lp_idle` bit is 1. It is read at 0x655.
- R4: The deep package counter adds one on each cycle where `cstate` equals the configured code and at least one `lp_idle` bit is 1. It is read at 0x656.
- R5: A write with `wr_addr == 0x652` loads `wr_data[3:0]` into the configuration code. The new code is used for deep matching from the following cycle. A read at 0x652 returns the code zero-extended. The code resets to 6.
- R6: After reset, every counter reads zero.
- R7: Counters are `CNT_W` bits wide and wrap from all-ones to zero with no other effect.
- R8: A read issued with `rd_en` in a cycle returns, one cycle later with `rd_valid` high, the value the addressed register held in that cycle, before that cycle's increment. `rd_data` holds its value while no read is issued.
- R9: A read of an unmapped address, or a thread or core index past the last instance, returns zero. A write to any address other than 0x652 leaves the configuration code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lp_idle | input | NUM_LP | Per-thread forced-idle flags |
| cstate | input | 4 | Current package C-state code |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 12 | Write address |
| wr_data | input | 4 | Write data (configuration code) |
| rd_en | input | 1 | Read request |
| rd_addr | input | 12 | Read address |
| rd_idx | input | IDX_W | Thread or core instance for a read |
| rd_valid | output | 1 | Read response valid |
| rd_data | output | CNT_W | Read response data |

## Verification
The bench uses a narrow counter width so that sustained idle makes the counters roll over. A design that saturated or carried past the top bit would return a wrong value after the wrap. Cycles where the C-state code equals the configured code are biased in, with reconfiguration mixed through the run. This exposes a deep counter that compares against a stale or reset code, or one that matches without requiring an idle thread. Reads and writes go to unmapped addresses, to a non-configuration address and to out-of-range core indices. An aliased decode would then return a live counter or corrupt the configuration code. Back-to-back reads and idle gaps between reads expose a response that returns the post-increment value or drifts while no read is pending.

// File: rtl/idle_res_pkg.sv
package idle_res_pkg;
    localparam int ADDR_W = 12;
    localparam int CST_W  = 4;

    localparam logic [ADDR_W-1:0] A_CFG  = 12'h652;
    localparam logic [ADDR_W-1:0] A_CORE = 12'h653;
    localparam logic [ADDR_W-1:0] A_SHAL = 12'h655;
    localparam logic [ADDR_W-1:0] A_DEEP = 12'h656;
    localparam logic [ADDR_W-1:0] A_THR  = 12'hDB2;

    localparam logic [CST_W-1:0] CST_SHALLOW = 4'd2;
    localparam logic [CST_W-1:0] CFG_RESET   = 4'd6;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;
endpackage

// File: rtl/res_counter.sv
module res_counter #(
    parameter int W = 64
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (inc) cnt <= cnt + W'(1);
    end

    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        inc |=> cnt == $past(cnt) + W'(1));

    // R1
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !inc |=> $stable(cnt));
endmodule

// File: rtl/idle_grouper.sv
module idle_grouper #(
    parameter int NUM_LP      = 4,
    parameter int LP_PER_CORE = 2,
    localparam int NUM_CORE   = NUM_LP / LP_PER_CORE
) (
    input  logic [NUM_LP-1:0]   lp_idle,
    output logic [NUM_CORE-1:0] core_idle,
    output logic                any_idle
);
    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        assign core_idle[c] = |lp_idle[c*LP_PER_CORE +: LP_PER_CORE];
    end
    assign any_idle = |core_idle;
endmodule

// File: rtl/res_read_port.sv
module res_read_port
    import idle_res_pkg::*;
#(
    parameter int W        = 64,
    parameter int NUM_LP   = 4,
    parameter int NUM_CORE = 2,
    parameter int IDX_W    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [W-1:0]      thr_cnt  [NUM_LP],
    input  logic [W-1:0]      core_cnt [NUM_CORE],
    input  logic [W-1:0]      shal_cnt,
    input  logic [W-1:0]      deep_cnt,
    input  logic [CST_W-1:0]  cfg_code,
    output logic              rd_valid,
    output logic [W-1:0]      rd_data
);
    rd_state_e state_q, state_d;
    logic [W-1:0] sel;
    logic         unmapped;

    always_comb begin
        sel      = '0;
        unmapped = 1'b0;
        unique case (rd_addr)
            A_THR: begin
                unmapped = 1'b1;
                for (int i = 0; i < NUM_LP; i++)
                    if (rd_idx == IDX_W'(i)) begin
                        sel      = thr_cnt[i];
                        unmapped = 1'b0;
                    end
            end
            A_CORE: begin
                unmapped = 1'b1;
                for (int c = 0; c < NUM_CORE; c++)
                    if (rd_idx == IDX_W'(c)) begin
                        sel      = core_cnt[c];
                        unmapped = 1'b0;
                    end
            end
            A_SHAL:  sel = shal_cnt;
            A_DEEP:  sel = deep_cnt;
            A_CFG:   sel = W'(cfg_code);
            default: unmapped = 1'b1;
        endcase
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RD_IDLE: if (rd_en) state_d = RD_RESP;
            RD_RESP: if (!rd_en) state_d = RD_IDLE;
            default: state_d = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RD_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_data <= '0;
        else if (rd_en) rd_data <= sel;
    end

    assign rd_valid = (state_q == RD_RESP);

    // R8
    resp_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R8
    resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && unmapped) |=> rd_data == '0);
endmodule

// File: rtl/idle_residency_bank.sv
module idle_residency_bank
    import idle_res_pkg::*;
#(
    parameter int NUM_LP      = 4,
    parameter int LP_PER_CORE = 2,
    parameter int CNT_W       = 64,
    localparam int NUM_CORE   = NUM_LP / LP_PER_CORE,
    localparam int IDX_W      = (NUM_LP > 1) ? $clog2(NUM_LP) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_LP-1:0] lp_idle,
    input  logic [3:0]        cstate,
    input  logic              wr_en,
    input  logic [11:0]       wr_addr,
    input  logic [3:0]        wr_data,
    input  logic              rd_en,
    input  logic [11:0]       rd_addr,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic              rd_valid,
    output logic [CNT_W-1:0]  rd_data
);
    logic [NUM_CORE-1:0] core_idle;
    logic                any_idle;
    logic [CST_W-1:0]    cfg_q;
    logic                shal_inc, deep_inc;
    logic [CNT_W-1:0]    thr_cnt  [NUM_LP];
    logic [CNT_W-1:0]    core_cnt [NUM_CORE];
    logic [CNT_W-1:0]    shal_cnt, deep_cnt;

    idle_grouper #(.NUM_LP(NUM_LP), .LP_PER_CORE(LP_PER_CORE)) u_group (
        .lp_idle  (lp_idle),
        .core_idle(core_idle),
        .any_idle (any_idle)
    );

    always_ff @(posedge clk) begin
        if (!rst_n)                         cfg_q <= CFG_RESET;
        else if (wr_en && wr_addr == A_CFG) cfg_q <= wr_data;
    end

    assign shal_inc = any_idle && (cstate == CST_SHALLOW);
    assign deep_inc = any_idle && (cstate == cfg_q);

    for (genvar i = 0; i < NUM_LP; i++) begin : g_thr
        res_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(lp_idle[i]), .cnt(thr_cnt[i]));
    end

    for (genvar c = 0; c < NUM_CORE; c++) begin : g_core
        res_counter #(.W(CNT_W)) u_cnt (
            .clk(clk), .rst_n(rst_n), .inc(core_idle[c]), .cnt(core_cnt[c]));
    end

    res_counter #(.W(CNT_W)) u_shal (
        .clk(clk), .rst_n(rst_n), .inc(shal_inc), .cnt(shal_cnt));
    res_counter #(.W(CNT_W)) u_deep (
        .clk(clk), .rst_n(rst_n), .inc(deep_inc), .cnt(deep_cnt));

    res_read_port #(
        .W(CNT_W), .NUM_LP(NUM_LP), .NUM_CORE(NUM_CORE), .IDX_W(IDX_W)
    ) u_rd (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .rd_idx  (rd_idx),
        .thr_cnt (thr_cnt),
        .core_cnt(core_cnt),
        .shal_cnt(shal_cnt),
        .deep_cnt(deep_cnt),
        .cfg_code(cfg_q),
        .rd_valid(rd_valid),
        .rd_data (rd_data)
    );

    // R5
    cfg_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == A_CFG) |=> $stable(cfg_q));

    // R3
    shallow_needs_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shal_inc |-> (|lp_idle));

    // R2
    core_needs_thread_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(core_idle) <= $countones(lp_idle));
endmodule

// File: tb/test_idle_residency_bank.sv
module test_idle_residency_bank;
    localparam int CLK_PERIOD = 10;
    localparam int NLP = 4;
    localparam int LPC = 2;
    localparam int NCO = NLP / LPC;
    localparam int CW  = 10;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NLP-1:0] lp_idle = '0;
    logic [3:0]     cstate = '0;
    logic           wr_en = 1'b0;
    logic [11:0]    wr_addr = '0;
    logic [3:0]     wr_data = '0;
    logic           rd_en = 1'b0;
    logic [11:0]    rd_addr = '0;
    logic [1:0]     rd_idx = '0;
    logic           rd_valid;
    logic [CW-1:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [CW-1:0] m_thr [NLP];
    logic [CW-1:0] m_core [NCO];
    logic [CW-1:0] m_sh, m_dp;
    logic [3:0]    m_cfg;

    always #(CLK_PERIOD/2) clk = ~clk;

    idle_residency_bank #(.NUM_LP(NLP), .LP_PER_CORE(LPC), .CNT_W(CW)) i_idle_residency_bank (
        .clk(clk), .rst_n(rst_n), .lp_idle(lp_idle), .cstate(cstate),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_idx(rd_idx),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    function automatic logic [CW-1:0] model_read(input logic [11:0] a, input logic [1:0] ix);
        case (a)
            12'hDB2: return m_thr[ix];
            12'h653: return (int'(ix) < NCO) ? m_core[ix] : '0;
            12'h655: return m_sh;
            12'h656: return m_dp;
            12'h652: return CW'(m_cfg);
            default: return '0;
        endcase
    endfunction

    function automatic string tag_of(input logic [11:0] a);
        case (a)
            12'hDB2: return "R1";
            12'h653: return "R2";
            12'h655: return "R3";
            12'h656: return "R4";
            12'h652: return "R5";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input string tag, input logic [CW-1:0] act, input logic [CW-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < NLP; i++) m_thr[i] = '0;
        for (int c = 0; c < NCO; c++) m_core[c] = '0;
        m_sh = '0; m_dp = '0; m_cfg = 4'd6;
    endtask

    // Drives one cycle from a negedge; checks any read at the following negedge.
    task automatic step(input logic [NLP-1:0] idl, input logic [3:0] cs,
                        input logic rd, input logic [11:0] ra, input logic [1:0] ri,
                        input logic wr, input logic [11:0] wa, input logic [3:0] wd,
                        input string tag);
        logic [CW-1:0] exp;
        lp_idle = idl; cstate = cs; rd_en = rd; rd_addr = ra; rd_idx = ri;
        wr_en = wr; wr_addr = wa; wr_data = wd;
        exp = model_read(ra, ri);
        @(posedge clk);
        for (int i = 0; i < NLP; i++) if (idl[i]) m_thr[i] = m_thr[i] + 1'b1;
        for (int c = 0; c < NCO; c++) if (|idl[c*LPC +: LPC]) m_core[c] = m_core[c] + 1'b1;
        if (|idl && cs == 4'd2)  m_sh = m_sh + 1'b1;
        if (|idl && cs == m_cfg) m_dp = m_dp + 1'b1;
        if (wr && wa == 12'h652) m_cfg = wd;
        @(negedge clk);
        if (rd) begin
            check({tag, " valid"}, CW'(rd_valid), CW'(1));
            check(tag, rd_data, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [11:0] addrs [7];
        logic [CW-1:0] held;
        addrs = '{12'hDB2, 12'h653, 12'h655, 12'h656, 12'h652, 12'h654, 12'h000};
        void'($urandom(32'h1D1E5EED));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R6: all readable registers start at zero, configuration at its reset code
        check("R8 idle valid", CW'(rd_valid), CW'(0));
        for (int i = 0; i < NLP; i++) step('0, 4'd0, 1'b1, 12'hDB2, 2'(i), 1'b0, '0, '0, "R6");
        for (int c = 0; c < NCO; c++) step('0, 4'd0, 1'b1, 12'h653, 2'(c), 1'b0, '0, '0, "R6");
        step('0, 4'd0, 1'b1, 12'h655, '0, 1'b0, '0, '0, "R6");
        step('0, 4'd0, 1'b1, 12'h656, '0, 1'b0, '0, '0, "R6");
        step('0, 4'd0, 1'b1, 12'h652, '0, 1'b0, '0, '0, "R5");

        // R9: out-of-range core index and non-config write
        step(4'hF, 4'd2, 1'b1, 12'h653, 2'd3, 1'b1, 12'h653, 4'd1, "R9");
        step('0, 4'd0, 1'b1, 12'h652, '0, 1'b0, '0, '0, "R9");
        // R4/R5: reconfigure to 3, then deep matches only from the next cycle
        step(4'h1, 4'd3, 1'b0, '0, '0, 1'b1, 12'h652, 4'd3, "R5");
        step(4'h1, 4'd3, 1'b1, 12'h656, '0, 1'b0, '0, '0, "R4");
        step('0, 4'd3, 1'b1, 12'h656, '0, 1'b0, '0, '0, "R4");
        // R8: response holds with no read pending
        held = rd_data;
        step(4'hF, 4'd2, 1'b0, '0, '0, 1'b0, '0, '0, "R8");
        check("R8 hold", rd_data, held);
        check("R8 drop", CW'(rd_valid), CW'(0));

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            logic [3:0] cs;
            logic [11:0] ra;
            int pick;
            pick = $urandom % 4;
            cs = (pick == 0) ? 4'd2 : (pick == 1) ? m_cfg : 4'($urandom % 16);
            ra = addrs[$urandom % 7];
            step(4'($urandom), cs, ($urandom % 3) == 0, ra, 2'($urandom),
                 ($urandom % 16) == 0, ($urandom % 2) ? 12'h652 : 12'h653,
                 4'($urandom), tag_of(ra));
        end

        // R7: sustained idle drives every counter through a wrap
        for (int n = 0; n < 1100; n++) step(4'hF, 4'd2, 1'b0, '0, '0, 1'b0, '0, '0, "R7");
        step('0, 4'd0, 1'b1, 12'hDB2, 2'd0, 1'b0, '0, '0, "R7");
        step('0, 4'd0, 1'b1, 12'h653, 2'd1, 1'b0, '0, '0, "R7");
        step('0, 4'd0, 1'b1, 12'h655, '0, 1'b0, '0, '0, "R7");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule